// File: doc/BRIEF.md
# Bus-mapped LED, pushbutton and slide-switch port

This block is a small I/O port on a simple parallel host bus. It has a byte-wide write path, a byte-wide read path and a short address. It drives sixteen active-low discrete LEDs from two write-only byte registers. It returns the levels of sixteen active-high pushbuttons and eight slide switches through a read multiplexer.

Reads and writes use the same low addresses but reach different devices. A write to address 0 or 1 loads an LED byte. A read from address 0 or 1 returns a button byte. The LED registers cannot be read back.

Each button and switch line is an asynchronous level. Every line passes through a two-flop synchronizer, which samples it on every clock. The read data is a combinational selection of the synchronized values, so the host sees the current state whenever it reads. Debouncing is left to the host.

Top module: `ledsw_port`

## Requirements
- R1: A write (`wr_en` high at a rising clock edge) to address 0 loads LEDs 0..7 from `wdata[7:0]`, and one to address 1 loads LEDs 8..15. The new value appears on `led_n` right after that edge, and LED n always follows register bit n.
- R2: `led_n` is the bitwise inverse of the stored LED bits. A stored 1 drives its line low, which lights the LED.
- R3: While `rst_n` is low, both LED registers and all synchronizer stages are zero. All sixteen `led_n` lines are high, and reads of addresses 0, 1 and 2 return 0x00.
- R4: A write to any address other than 0 or 1 changes no LED line.
- R5: A read of address 0 returns buttons 0..7, with button 0 in bit 0. A read of address 1 returns buttons 8..15, with button 8 in bit 0. The LED registers never appear on `rd_data`.
- R6: A read of address 2 returns the eight switch levels, with switch 0 in bit 0.
- R7: A read of any address above 2 returns 0x00.
- R8: A button or switch level sampled at rising edge k shows up on `rd_data` after edge k+1, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address for both read and write |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| btn_in | input | 16 | Raw pushbutton levels, active high |
| sw_in | input | 8 | Raw slide-switch levels |
| led_n | output | 16 | LED drive lines, active low |

## Verification
A corrupted LED register shows on `led_n` right after the edge that stored it, because the lines have no further stage. A fault in the synchronizer chain or in the read multiplexer shows only while the matching address is selected. It also shows two edges late, at the point where a stale or shifted input byte reaches `rd_data`. The bench therefore compares both outputs on every cycle against a model that delays the inputs in a queue. It steps through every address while the button and switch patterns change, so that a one-cycle latency error or a byte swap appears within a cycle or two.

// File: rtl/ledsw_port.sv
module ledsw_port #(
  parameter int ADDR_W = 4,
  parameter int N_LED  = 16,
  parameter int N_BTN  = 16,
  parameter int N_SW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rd_data,
  input  logic [N_BTN-1:0]  btn_in,
  input  logic [N_SW-1:0]   sw_in,
  output logic [N_LED-1:0]  led_n
);
  localparam int LED_BYTES = N_LED / 8;
  localparam int IN_W      = N_BTN + N_SW;

  logic [N_LED-1:0] led_q;
  logic [IN_W-1:0]  meta_q, sync_q;
  logic [N_BTN-1:0] btn_s;
  logic [N_SW-1:0]  sw_s;

  for (genvar g = 0; g < LED_BYTES; g++) begin : g_led
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        led_q[g*8 +: 8] <= '0;
      else if (wr_en && addr == ADDR_W'(g))
        led_q[g*8 +: 8] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= {sw_in, btn_in};
      sync_q <= meta_q;
    end

  assign btn_s = sync_q[N_BTN-1:0];
  assign sw_s  = sync_q[IN_W-1:N_BTN];
  assign led_n = ~led_q;

  always_comb
    case (addr)
      ADDR_W'(0): rd_data = btn_s[7:0];
      ADDR_W'(1): rd_data = btn_s[15:8];
      ADDR_W'(2): rd_data = sw_s;
      default:    rd_data = 8'h00;
    endcase
endmodule

module ledsw_port_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [7:0]        wdata,
  input logic [7:0]        rd_data,
  input logic [15:0]       btn_in,
  input logic [7:0]        sw_in,
  input logic [15:0]       led_n
);
  logic [1:0] up_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;

  // R1
  lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0) |=> led_n[7:0] == ~$past(wdata));
  // R2
  hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(1)) |=> led_n[15:8] == ~$past(wdata));
  // R4
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr > ADDR_W'(1)) |=> $stable(led_n));
  // R7
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > ADDR_W'(2)) |-> rd_data == 8'h00);
  // R8
  sw_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt == 2'd3 && addr == ADDR_W'(2)) |-> rd_data == $past(sw_in, 2));
  // R3
  always_ff @(posedge clk)
    if (!rst_n) reset_off_chk: assert (led_n == 16'hFFFF);
endmodule

bind ledsw_port ledsw_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rd_data(rd_data), .btn_in(btn_in), .sw_in(sw_in), .led_n(led_n)
);

// File: tb/sim_ledsw_port.sv
module sim_ledsw_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rd_data;
  logic [15:0] btn_in = '0;
  logic [7:0]  sw_in = '0;
  logic [15:0] led_n;

  int total = 0, bad = 0;
  bit done = 0;
  logic [15:0] m_led;
  logic [23:0] hist[$];

  always #5 clk = ~clk;

  ledsw_port u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rd_data(rd_data), .btn_in(btn_in), .sw_in(sw_in), .led_n(led_n));

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    logic [23:0] v = hist[0];
    case (a)
      4'd0: return v[7:0];
      4'd1: return v[15:8];
      4'd2: return v[23:16];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [3:0] a, input logic we, input logic [7:0] wd,
                     input logic [15:0] b, input logic [7:0] s, input string ltag);
    string rtag;
    addr = a; wr_en = we; wdata = wd; btn_in = b; sw_in = s;
    @(posedge clk);
    if (we && a == 4'd0) m_led[7:0] = wd;
    if (we && a == 4'd1) m_led[15:8] = wd;
    hist.push_back({s, b});
    if (hist.size() > 2) void'(hist.pop_front());
    @(negedge clk);
    chk(ltag, led_n, ~m_led);
    rtag = (a < 4'd2) ? "R5/R8 read" : (a == 4'd2) ? "R6/R8 read" : "R7 read";
    chk(rtag, {8'h00, rd_data}, {8'h00, exp_rd(a)});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    btn_in = 16'hFFFF; sw_in = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R3 reset leds", led_n, 16'hFFFF);
    for (int a = 0; a < 3; a++) begin
      addr = 4'(a); #1;
      chk("R3 reset read", {8'h00, rd_data}, 16'h0000);
    end
    m_led = '0; hist = {24'h0, 24'h0};
    btn_in = '0; sw_in = '0; addr = '0;
    rst_n = 1'b1;
    cyc(4'd0, 1, 8'hA5, 16'h0000, 8'h00, "R1/R2 low byte");
    cyc(4'd1, 1, 8'h3C, 16'h0000, 8'h00, "R1/R2 high byte");
    cyc(4'd2, 1, 8'hFF, 16'h0000, 8'h00, "R4 write addr2");
    cyc(4'd3, 1, 8'h11, 16'h0000, 8'h00, "R4 write addr3");
    cyc(4'd15, 1, 8'h77, 16'h0000, 8'h00, "R4 write addr15");
    cyc(4'd0, 0, 8'h00, 16'h0000, 8'h00, "R5 leds not readable");
    cyc(4'd0, 0, 8'h00, 16'h8001, 8'h00, "R8 hold");
    cyc(4'd0, 0, 8'h00, 16'h8001, 8'h00, "R8 hold");
    cyc(4'd1, 0, 8'h00, 16'h8001, 8'h00, "R8 hold");
    cyc(4'd2, 0, 8'h00, 16'h8001, 8'h81, "R8 hold");
    cyc(4'd2, 0, 8'h00, 16'h8001, 8'h81, "R8 hold");
    cyc(4'd2, 0, 8'h00, 16'h8001, 8'h81, "R8 hold");
    for (int i = 0; i < 64; i++) begin
      logic [15:0] b = 16'(i * 16'h1357) ^ 16'h5A0F;
      logic [7:0]  s = 8'(i * 37 + 3);
      cyc(4'(i % 6), (i % 3) == 0, 8'(i * 29), b, s, "R1/R2/R4 mixed");
    end
    for (int i = 0; i < 16; i++) begin
      cyc(4'd0, 0, 8'h00, 16'(1 << i), 8'(1 << (i % 8)), "R5 walk");
      cyc(4'd1, 0, 8'h00, 16'(1 << i), 8'(1 << (i % 8)), "R5 walk");
      cyc(4'd2, 0, 8'h00, 16'(1 << i), 8'(1 << (i % 8)), "R6 walk");
      cyc(4'd7, 1, 8'hFF, 16'(1 << i), 8'(1 << (i % 8)), "R4/R7 walk");
    end
    cyc(4'd0, 1, 8'h00, 16'hFFFF, 8'hFF, "R2 clear low");
    cyc(4'd1, 1, 8'h00, 16'hFFFF, 8'hFF, "R2 clear high");
    cyc(4'd0, 0, 8'h00, 16'hFFFF, 8'hFF, "R2 all off");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule